// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Unit

This block is an evaluation-stack datapath for zero-address arithmetic. A command port takes one command per cycle. Push places a data word on top of an internal register stack. Pop removes the top entry and returns it on an output port, marked by a valid strobe. The operations add, sub, mul and div each take the two uppermost entries as implicit operands, remove both, and leave a single result in their place. For the ordered operations the entry below the top is the left operand.

Add, sub and mul finish in the cycle that accepts them. Div uses a shift-subtract divider that takes one cycle per data bit. While it runs, a busy output is held high and the command port accepts nothing. A command that is held on the port during the divide is taken once busy falls. Errors are reported as one-cycle pulses: overflow for a push to a full stack, underflow for a command that lacks operands, and divide-by-zero.

Top module: `stack_alu`

## Requirements
- R1: Opcodes on cmd_op_i are 0 push, 1 pop, 2 add, 3 sub, 4 mul, 5 div. A command is accepted on a rising edge with cmd_valid_i high and busy_o low. An accepted pop raises pop_valid_o for one cycle on the next cycle, with pop_data_o equal to the top entry. Entries come out in last-in first-out order.
- R2: Add and sub replace the two uppermost entries with one result, where the left operand is the entry below the top. Pushing X then Y and issuing sub leaves X-Y modulo 2^W.
- R3: Mul replaces the two uppermost entries with the low W bits of their product.
- R4: Div replaces the two uppermost entries with the unsigned truncated quotient (below-top divided by top). busy_o is high for exactly W cycles, starting in the cycle after acceptance.
- R5: While busy_o is high, no command is accepted. A command held through the divide is taken exactly once, after busy_o falls, and it acts on the stack that holds the quotient.
- R6: A pop on an empty stack, or an add, sub, mul or div with fewer than two entries, raises unf_o for one cycle on the next cycle and leaves the stack unchanged.
- R7: A push to a stack holding DEPTH entries raises ovf_o for one cycle on the next cycle, and the pushed word is discarded.
- R8: Div with a zero top entry puts all ones in place of the quotient. dz_o is high for one cycle, in the cycle after busy_o falls.
- R9: With A, B and C pushed in the order push A, push B, mul, push A, push C, push B, mul, add, sub, the stack holds exactly one entry, equal to A*B-(A+C*B).
- R10: After reset the stack is empty and busy_o, pop_valid_o, ovf_o, unf_o and dz_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 3 | Opcode |
| cmd_data_i | input | W | Word for push |
| busy_o | output | 1 | Divide in progress; commands refused |
| pop_valid_o | output | 1 | Pop result strobe |
| pop_data_o | output | W | Popped word |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |
| dz_o | output | 1 | Divide-by-zero pulse |

## Verification
In the same cycle the divider completes, three things happen: the quotient is written, busy falls, and a command that has waited on the port becomes acceptable. The bench provokes this by issuing div and then holding a pop on the port for the whole divide. The scoreboard then requires exactly one pop result, and that result must be the quotient. A following pop must report underflow, which shows the held command was not taken twice and did not act on the pre-divide stack. The same boundary is checked for divide-by-zero: the all-ones result and the dz_o pulse must coincide with the drop of busy_o.

// File: rtl/stack_alu_pkg.sv
package stack_alu_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5
  } op_e;
endpackage

// File: rtl/stack_regs.sv
module stack_regs #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          merge_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  top_o,
  output logic [W-1:0]  next_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] top_idx, nxt_idx, wr_idx;
  logic          wr_en;

  assign top_idx = PW'(cnt_q - CW'(1));
  assign nxt_idx = PW'(cnt_q - CW'(2));
  // merge overwrites the below-top slot, push writes the first free slot
  assign wr_idx  = push_i ? PW'(cnt_q) : nxt_idx;
  assign wr_en   = push_i | merge_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (push_i)          cnt_q <= cnt_q + CW'(1);
    else if (pop_i | merge_i) cnt_q <= cnt_q - CW'(1);
  end

  assign top_o  = (cnt_q != '0)     ? mem[top_idx] : '0;
  assign next_o = (cnt_q >= CW'(2)) ? mem[nxt_idx] : '0;
  assign cnt_o  = cnt_q;

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r6_one_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({push_i, pop_i, merge_i}));
endmodule

// File: rtl/stack_arith.sv
module stack_arith
  import stack_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op_i,
  input  logic [W-1:0] lhs_i,
  input  logic [W-1:0] rhs_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = lhs_i + rhs_i;
      OP_SUB:  res_o = lhs_i - rhs_i;
      OP_MUL:  res_o = lhs_i * rhs_i;  // low half only
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/stack_div.sv
module stack_div #(
  parameter int W  = 16,
  localparam int NW = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dvnd_i,
  input  logic [W-1:0] dvsr_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         dz_o,
  output logic [W-1:0] quot_o
);
  logic [W:0]    rem_q, r_sh, diff, rem_n;
  logic [W-1:0]  q_q, q_n, dvsr_q;
  logic [NW-1:0] cnt_q;
  logic          busy_q, dz_q, qbit;

  assign r_sh  = {rem_q[W-1:0], q_q[W-1]};
  assign diff  = r_sh - {1'b0, dvsr_q};
  assign qbit  = ~diff[W];
  assign rem_n = qbit ? diff : r_sh;
  assign q_n   = {q_q[W-2:0], qbit};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; q_q <= '0; dvsr_q <= '0;
      cnt_q <= '0; busy_q <= 1'b0; dz_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      q_q    <= dvnd_i;
      dvsr_q <= dvsr_i;
      cnt_q  <= NW'(W);
      busy_q <= 1'b1;
      dz_q   <= (dvsr_i == '0);
    end else if (busy_q) begin
      rem_q <= rem_n;
      q_q   <= q_n;
      cnt_q <= cnt_q - NW'(1);
      if (done_o) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == NW'(1));
  assign dz_o   = dz_q;
  assign quot_o = dz_q ? '1 : q_n;

  a_r5_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  a_r4_cnt_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q != '0);
  a_r4_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
endmodule

// File: rtl/stack_alu.sv
module stack_alu
  import stack_alu_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_valid_i,
  input  logic [2:0]   cmd_op_i,
  input  logic [W-1:0] cmd_data_i,
  output logic         busy_o,
  output logic         pop_valid_o,
  output logic [W-1:0] pop_data_o,
  output logic         ovf_o,
  output logic         unf_o,
  output logic         dz_o
);
  op_e           op;
  logic          accept, div_busy, div_done, div_dz, div_start;
  logic          push_en, pop_en, merge_en, ovf_n, unf_n;
  logic [W-1:0]  top_w, next_w, arith_res, quot_w, merge_data, wdata;
  logic [CW-1:0] cnt_w;
  logic          pop_valid_q, ovf_q, unf_q, dz_q;
  logic [W-1:0]  pop_data_q;

  assign op     = op_e'(cmd_op_i);
  assign accept = cmd_valid_i && !div_busy;

  always_comb begin
    push_en = 1'b0; pop_en = 1'b0; merge_en = 1'b0; div_start = 1'b0;
    ovf_n = 1'b0; unf_n = 1'b0;
    merge_data = arith_res;
    if (div_done) begin
      merge_en   = 1'b1;
      merge_data = quot_w;
    end else if (accept) begin
      unique case (op)
        OP_PUSH: if (cnt_w == CW'(DEPTH)) ovf_n = 1'b1; else push_en = 1'b1;
        OP_POP:  if (cnt_w == '0) unf_n = 1'b1; else pop_en = 1'b1;
        OP_ADD, OP_SUB, OP_MUL:
                 if (cnt_w < CW'(2)) unf_n = 1'b1; else merge_en = 1'b1;
        OP_DIV:  if (cnt_w < CW'(2)) unf_n = 1'b1; else div_start = 1'b1;
        default: ;
      endcase
    end
  end

  assign wdata = push_en ? cmd_data_i : merge_data;

  stack_regs #(.W(W), .DEPTH(DEPTH)) u_regs (
    .clk_i, .rst_ni,
    .push_i(push_en), .pop_i(pop_en), .merge_i(merge_en), .wdata_i(wdata),
    .top_o(top_w), .next_o(next_w), .cnt_o(cnt_w)
  );

  stack_arith #(.W(W)) u_arith (
    .op_i(op), .lhs_i(next_w), .rhs_i(top_w), .res_o(arith_res)
  );

  stack_div #(.W(W)) u_div (
    .clk_i, .rst_ni,
    .start_i(div_start), .dvnd_i(next_w), .dvsr_i(top_w),
    .busy_o(div_busy), .done_o(div_done), .dz_o(div_dz), .quot_o(quot_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_valid_q <= 1'b0; pop_data_q <= '0;
      ovf_q <= 1'b0; unf_q <= 1'b0; dz_q <= 1'b0;
    end else begin
      pop_valid_q <= pop_en;
      if (pop_en) pop_data_q <= top_w;
      ovf_q <= ovf_n;
      unf_q <= unf_n;
      dz_q  <= div_done && div_dz;
    end
  end

  assign busy_o      = div_busy;
  assign pop_valid_o = pop_valid_q;
  assign pop_data_o  = pop_data_q;
  assign ovf_o       = ovf_q;
  assign unf_o       = unf_q;
  assign dz_o        = dz_q;

  a_r5_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_busy && !div_done |=> $stable(cnt_w));
  a_r6_unf_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> $stable(cnt_w));
  a_r7_ovf_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $stable(cnt_w) && cnt_w == CW'(DEPTH));
  a_r1_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o |-> cnt_w == $past(cnt_w) - CW'(1));
  a_r8_dz_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dz_o |-> top_w == '1 && !busy_o);
endmodule

// File: tb/stack_alu_test.sv
`timescale 1ns/1ps
module stack_alu_test;
  localparam int W = 16;
  localparam int DEPTH = 8;

  logic clk = 0, rst_ni = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [W-1:0] cmd_data = 0;
  logic busy_o, pop_valid_o, ovf_o, unf_o, dz_o;
  logic [W-1:0] pop_data_o;

  int checks = 0, errors = 0;
  logic [W-1:0] mdl[$];
  logic [W-1:0] sb_val[$];
  string sb_tag[$];

  always #4 clk = ~clk;

  stack_alu #(.W(W), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni, .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .busy_o, .pop_valid_o, .pop_data_o,
    .ovf_o, .unf_o, .dz_o
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare every pop result with the scoreboard head
  always @(negedge clk) begin
    if (rst_ni && pop_valid_o) begin
      if (sb_val.size() == 0) chk(0, "R1 unexpected pop", 32'(pop_data_o), 0);
      else begin
        automatic logic [W-1:0] e = sb_val.pop_front();
        automatic string t = sb_tag.pop_front();
        chk(pop_data_o == e, t, 32'(pop_data_o), 32'(e));
      end
    end
  end

  task automatic do_cmd(input logic [2:0] op, input logic [W-1:0] d, input string tag);
    bit e_unf = 0, e_ovf = 0, e_dz = 0;
    logic [W-1:0] l, r, res;
    int n;
    case (op)
      3'd0: if (mdl.size() == DEPTH) e_ovf = 1; else mdl.push_back(d);
      3'd1: if (mdl.size() == 0) e_unf = 1;
            else begin sb_val.push_back(mdl.pop_back()); sb_tag.push_back(tag); end
      default: if (mdl.size() < 2) e_unf = 1;
        else begin
          r = mdl.pop_back(); l = mdl.pop_back();
          case (op)
            3'd2: res = l + r;
            3'd3: res = l - r;
            3'd4: res = W'(32'(l) * 32'(r));
            default: begin e_dz = (r == 0); res = e_dz ? '1 : l / r; end
          endcase
          mdl.push_back(res);
        end
    endcase
    @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_data = d;
    @(posedge clk);
    @(negedge clk); cmd_valid = 0;
    chk(unf_o == e_unf, {tag, " unf"}, 32'(unf_o), 32'(e_unf));
    chk(ovf_o == e_ovf, {tag, " ovf"}, 32'(ovf_o), 32'(e_ovf));
    if (op == 3'd5 && !e_unf) begin
      n = 0;
      while (busy_o) begin n++; @(negedge clk); end
      chk(n == W, "R4 busy cycles", 32'(n), 32'(W));
      chk(dz_o == e_dz, {tag, " dz"}, 32'(dz_o), 32'(e_dz));
    end
  endtask

  task automatic drain(input string tag);
    while (mdl.size() > 0) do_cmd(3'd1, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy_o, pop_valid_o, ovf_o, unf_o, dz_o} == 0, "R10 outputs",
        32'({busy_o, pop_valid_o, ovf_o, unf_o, dz_o}), 0);
    rst_ni = 1;
    @(negedge clk);
    do_cmd(3'd1, 0, "R10 empty after reset");

    // R1 LIFO
    do_cmd(3'd0, 16'h1111, "R1"); do_cmd(3'd0, 16'h2222, "R1"); do_cmd(3'd0, 16'h3333, "R1");
    drain("R1 lifo");

    // R2 sub ordering and add
    do_cmd(3'd0, 16'd10, "R2"); do_cmd(3'd0, 16'd3, "R2"); do_cmd(3'd3, 0, "R2");
    do_cmd(3'd1, 0, "R2 sub 10-3");
    do_cmd(3'd0, 16'd3, "R2"); do_cmd(3'd0, 16'd10, "R2"); do_cmd(3'd3, 0, "R2");
    do_cmd(3'd1, 0, "R2 sub wrap");
    do_cmd(3'd0, 16'hFFF0, "R2"); do_cmd(3'd0, 16'h0020, "R2"); do_cmd(3'd2, 0, "R2");
    do_cmd(3'd1, 0, "R2 add wrap");

    // R3 mul low half
    do_cmd(3'd0, 16'd300, "R3"); do_cmd(3'd0, 16'd300, "R3"); do_cmd(3'd4, 0, "R3");
    do_cmd(3'd1, 0, "R3 mul wrap");

    // R4 div
    do_cmd(3'd0, 16'd100, "R4"); do_cmd(3'd0, 16'd7, "R4"); do_cmd(3'd5, 0, "R4");
    do_cmd(3'd1, 0, "R4 quotient");
    do_cmd(3'd0, 16'hFFFF, "R4"); do_cmd(3'd0, 16'd3, "R4"); do_cmd(3'd5, 0, "R4");
    do_cmd(3'd1, 0, "R4 quotient max");
    do_cmd(3'd0, 16'd3, "R4"); do_cmd(3'd0, 16'd9, "R4"); do_cmd(3'd5, 0, "R4");
    do_cmd(3'd1, 0, "R4 quotient zero");

    // R8 divide by zero
    do_cmd(3'd0, 16'd5, "R8"); do_cmd(3'd0, 16'd0, "R8"); do_cmd(3'd5, 0, "R8");
    do_cmd(3'd1, 0, "R8 all ones");

    // R6 underflow, stack unchanged
    do_cmd(3'd0, 16'h00AB, "R6");
    do_cmd(3'd2, 0, "R6 add one entry");
    do_cmd(3'd5, 0, "R6 div one entry");
    do_cmd(3'd1, 0, "R6 entry kept");
    do_cmd(3'd4, 0, "R6 mul empty");

    // R7 overflow, word discarded
    for (int i = 0; i < DEPTH; i++) do_cmd(3'd0, W'(16'h0100 + i), "R7");
    do_cmd(3'd0, 16'hDEAD, "R7 push full");
    drain("R7 contents");
    do_cmd(3'd1, 0, "R7 nothing extra");

    // R9 expression A*B-(A+C*B), A=7 B=5 C=3
    do_cmd(3'd0, 16'd7, "R9"); do_cmd(3'd0, 16'd5, "R9"); do_cmd(3'd4, 0, "R9");
    do_cmd(3'd0, 16'd7, "R9"); do_cmd(3'd0, 16'd3, "R9"); do_cmd(3'd0, 16'd5, "R9");
    do_cmd(3'd4, 0, "R9"); do_cmd(3'd2, 0, "R9"); do_cmd(3'd3, 0, "R9");
    chk(mdl.size() == 1 && mdl[0] == 16'd13, "R9 model", 32'(mdl[0]), 13);
    do_cmd(3'd1, 0, "R9 result");
    do_cmd(3'd1, 0, "R9 single entry");

    // R5 pop held on the port through a divide
    do_cmd(3'd0, 16'd100, "R5"); do_cmd(3'd0, 16'd7, "R5");
    void'(mdl.pop_back()); void'(mdl.pop_back());
    sb_val.push_back(16'd14); sb_tag.push_back("R5 held pop");
    @(negedge clk); cmd_valid = 1; cmd_op = 3'd5;
    @(posedge clk);
    @(negedge clk); cmd_op = 3'd1;
    chk(busy_o == 1, "R5 busy", 32'(busy_o), 1);
    while (busy_o) @(negedge clk);
    @(posedge clk);
    @(negedge clk); cmd_valid = 0;
    chk(pop_valid_o == 1, "R5 held pop taken", 32'(pop_valid_o), 1);
    @(negedge clk);
    chk(pop_valid_o == 0, "R5 taken once", 32'(pop_valid_o), 0);
    do_cmd(3'd1, 0, "R5 stack empty");

    repeat (2) @(negedge clk);
    chk(sb_val.size() == 0, "R1 scoreboard drained", 32'(sb_val.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule